// File: doc/BRIEF.md
# PoE Classification Event Counter

This block follows the multi-event classification exchange on the powered side of a Power over Ethernet link. Its inputs are four digital levels from the front-end comparators: the cable voltage is in the low re-arm region, in the mark window (about 4.9 V to 10.1 V), or in the class window (about 13.7 V to 20.9 V), or power-on has been reached. Each level passes through its own debounce filter. A small tracker then counts class events, each one after the first separated from the last by a mark interval, until power-on arrives.

When power-on rises, the event count becomes a four-bit thermometer code on the identification flag outputs. The flags hold until the re-arm region is seen or power-on drops. Nothing flows through this block as a data stream, so there is no valid/ready handshake. Every pin is a plain level that the block samples on each clock.

Top module: `poe_class_counter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `id_flags` is 4'b0000.
- R2: A change on any region input counts only after the input has held its new value for `DEB_CYCLES` consecutive clocks. A pulse of `DEB_CYCLES-1` clocks has no effect.
- R3: A class event counts when the filtered class level is entered from the armed state or from a mark interval. Leaving the class window into no region and then returning, with no mark between, does not add an event.
- R4: Flag bits are bit 0 = Type-2, bit 1 = HD, bit 2 = 4-pair Type-2, bit 3 = 4-pair HD. Event counts 0 and 1 give 4'b0000, 2 gives 4'b0001, 3 gives 4'b0011, 4 gives 4'b0111 and 6 gives 4'b1111.
- R5: The reserved count of five gives the same flags as four, 4'b0111.
- R6: The count saturates at six, so seven or more class events give 4'b1111.
- R7: Flags stay 4'b0000 before power-on. They take the encoded count exactly `DEB_CYCLES+1` clocks after the raw power-on input rises, including a direct jump from the class window to power-on.
- R8: The re-arm region has priority over all other inputs. The resolved order is re-arm, then power-on, then class, then mark.
- R9: The filtered re-arm region clears the flags and the event count, so the next sequence counts from zero.
- R10: When filtered power-on falls, the flags clear. Class and mark activity and a new power-on rise with no re-arm region in between leave the flags at 4'b0000.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_rearm_rgn | input | 1 | Cable voltage is in the low re-arm region |
| in_mark_rgn | input | 1 | Cable voltage is in the mark window |
| in_class_rgn | input | 1 | Cable voltage is in the class window |
| in_power_ok | input | 1 | Power-on threshold reached |
| id_flags | output | 4 | Identification flags, thermometer coded (see R4) |

## Verification
The bench targets the cases where counting is easy to get wrong.

- A class glitch shorter than the filter window inside a mark interval must not add an event. A design that passes it through would report three events instead of two.
- Class, idle, class with no mark between must count once. A design that counts every class entry would raise the HD flag.
- The reserved count of five and counts past six must give 4'b0111 and 4'b1111. A wrapping or unmapped count would drop flags.
- After power-on falls, a fresh classification with no re-arm region must not raise the flags again.
- The exact cycle in which the flags appear is checked, so an extra or missing register stage is caught.

// File: rtl/poe_cls_pkg.sv
package poe_cls_pkg;

  localparam int MAX_EVENTS = 6;
  localparam int CNT_W      = $clog2(MAX_EVENTS + 1);
  localparam int NUM_LVL    = 4;
  localparam int FLAG_W     = 4;

  // index of each level in the packed raw vector
  localparam int LV_REARM = 0;
  localparam int LV_MARK  = 1;
  localparam int LV_CLASS = 2;
  localparam int LV_POWER = 3;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_MARK,
    RG_CLASS,
    RG_POWER,
    RG_REARM
  } region_t;

  typedef enum logic [1:0] {
    TS_ARMED,
    TS_CLASS,
    TS_MARK,
    TS_ENDED
  } track_t;

  // event count to cumulative thermometer flags; five maps like four
  function automatic logic [FLAG_W-1:0] count_to_flags(input logic [CNT_W-1:0] n);
    logic [FLAG_W-1:0] f;
    case (n)
      3'd2:          f = 4'b0001;
      3'd3:          f = 4'b0011;
      3'd4, 3'd5:    f = 4'b0111;
      3'd6, 3'd7:    f = 4'b1111;
      default:       f = 4'b0000;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/poe_level_filter.sv
module poe_level_filter #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_q
);
  localparam int DW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
  localparam logic [DW-1:0] LAST = DW'(DEB_CYCLES - 1);

  logic [DW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (raw_in == level_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q   <= '0;
      level_q <= raw_in;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/poe_event_tracker.sv
module poe_event_tracker
  import poe_cls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  region_t          region,
  output logic [CNT_W-1:0] evt_count,
  output track_t           track_st,
  output logic             latch_now
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_EVENTS);

  track_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    latch_now = 1'b0;
    case (region)
      RG_REARM: begin
        st_d  = TS_ARMED;
        cnt_d = '0;
      end
      RG_POWER: begin
        if (st_q != TS_ENDED) begin
          latch_now = 1'b1;
          st_d      = TS_ENDED;
        end
      end
      RG_CLASS: begin
        if (st_q == TS_ARMED || st_q == TS_MARK) begin
          st_d  = TS_CLASS;
          cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        end
      end
      RG_MARK: begin
        if (st_q == TS_CLASS) st_d = TS_MARK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TS_ARMED;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign evt_count = cnt_q;
  assign track_st  = st_q;
endmodule

// File: rtl/poe_flag_encoder.sv
module poe_flag_encoder
  import poe_cls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              latch_now,
  input  logic [CNT_W-1:0]  evt_count,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (clear)     flags_q <= '0;
    else if (latch_now) flags_q <= count_to_flags(evt_count);
  end
endmodule

// File: rtl/poe_class_counter.sv
module poe_class_counter
  import poe_cls_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_rearm_rgn,
  input  logic       in_mark_rgn,
  input  logic       in_class_rgn,
  input  logic       in_power_ok,
  output logic [3:0] id_flags
);
  logic [NUM_LVL-1:0] raw_lvl;
  logic [NUM_LVL-1:0] filt_lvl;
  region_t            region;
  logic [CNT_W-1:0]   evt_count;
  track_t             track_st;
  logic               latch_now;
  logic               flag_clear;

  assign raw_lvl[LV_REARM] = in_rearm_rgn;
  assign raw_lvl[LV_MARK]  = in_mark_rgn;
  assign raw_lvl[LV_CLASS] = in_class_rgn;
  assign raw_lvl[LV_POWER] = in_power_ok;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_filt
    poe_level_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_in  (raw_lvl[g]),
      .level_q (filt_lvl[g])
    );
  end

  // fixed priority: re-arm, power, class, mark
  always_comb begin
    if      (filt_lvl[LV_REARM]) region = RG_REARM;
    else if (filt_lvl[LV_POWER]) region = RG_POWER;
    else if (filt_lvl[LV_CLASS]) region = RG_CLASS;
    else if (filt_lvl[LV_MARK])  region = RG_MARK;
    else                         region = RG_NONE;
  end

  poe_event_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .region    (region),
    .evt_count (evt_count),
    .track_st  (track_st),
    .latch_now (latch_now)
  );

  assign flag_clear = (region == RG_REARM) || !filt_lvl[LV_POWER];

  poe_flag_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flag_clear),
    .latch_now (latch_now),
    .evt_count (evt_count),
    .flags_q   (id_flags)
  );
endmodule

// File: rtl/poe_class_counter_chk.sv
module poe_class_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] flags,
  input logic [2:0] evt_count,
  input logic       rearm_q,
  input logic       power_q,
  input logic [1:0] track_st
);
  // R4: flags always a cumulative thermometer code
  a_r4_thermo: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 4'b0000 || flags == 4'b0001 || flags == 4'b0011 ||
     flags == 4'b0111 || flags == 4'b1111));

  // R6: count never passes six
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    evt_count <= 3'd6);

  // R3: count grows by at most one per cycle
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_count == 3'd0) || (evt_count == $past(evt_count)) ||
    (evt_count == $past(evt_count) + 3'd1));

  // R9: filtered re-arm clears flags and count next cycle
  a_r9_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_q |=> (flags == 4'b0000 && evt_count == 3'd0));

  // R10: no flags without filtered power
  a_r10_power_low: assert property (@(posedge clk) disable iff (!rst_n)
    !power_q |=> flags == 4'b0000);

  // R7: flags leave zero only while power was present
  a_r7_latch_on_power: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flags) == 4'b0000 && flags != 4'b0000) |-> $past(power_q));

  // R10: once counting ended, count frozen until re-arm
  a_r10_ended_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (track_st == 2'd3 && !rearm_q) |=> $stable(evt_count));
endmodule

bind poe_class_counter poe_class_counter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flags     (id_flags),
  .evt_count (evt_count),
  .rearm_q   (filt_lvl[0]),
  .power_q   (filt_lvl[3]),
  .track_st  (track_st)
);

// File: tb/poe_class_counter_test.sv
`timescale 1ns/1ps
module poe_class_counter_test;
  localparam int DEB  = 4;
  localparam int HOLD = DEB + 3;

  // region codes for the drive task
  localparam int RN = 0, RM = 1, RC = 2, RP = 3, RR = 4;

  // {number of class events, expected flags}
  localparam logic [7:0] VEC [9] = '{
    {4'd0, 4'b0000}, {4'd1, 4'b0000}, {4'd2, 4'b0001},
    {4'd3, 4'b0011}, {4'd4, 4'b0111}, {4'd5, 4'b0111},
    {4'd6, 4'b1111}, {4'd7, 4'b1111}, {4'd9, 4'b1111}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       r_rearm = 1'b0, r_mark = 1'b0, r_class = 1'b0, r_power = 1'b0;
  logic [3:0] id_flags;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  poe_class_counter #(.DEB_CYCLES(DEB)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_rearm_rgn (r_rearm),
    .in_mark_rgn  (r_mark),
    .in_class_rgn (r_class),
    .in_power_ok  (r_power),
    .id_flags     (id_flags)
  );

  task automatic check(input string req, input logic [3:0] exp);
    n_checks++;
    if (id_flags !== exp) begin
      n_errors++;
      $display("FAIL %s: id_flags=%b expected=%b", req, id_flags, exp);
    end
  endtask

  task automatic drive(input int rg, input int cycles);
    @(negedge clk);
    r_rearm = (rg == RR);
    r_mark  = (rg == RM);
    r_class = (rg == RC);
    r_power = (rg == RP);
    repeat (cycles - 1) @(negedge clk);
  endtask

  // re-arm, then n class events separated by marks, ending in the class window
  task automatic classify(input int n);
    drive(RR, HOLD);
    drive(RN, HOLD);
    for (int i = 0; i < n; i++) begin
      if (i > 0) drive(RM, HOLD);
      drive(RC, HOLD);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 4'b0000);

    // table walk: R4 encoding, R5 reserved count, R6 saturation
    for (int k = 0; k < 9; k++) begin
      classify(int'(VEC[k][7:4]));
      drive(RP, HOLD);
      if (VEC[k][7:4] == 4'd5)      check("R5 count five", VEC[k][3:0]);
      else if (VEC[k][7:4] > 4'd6)  check("R6 saturation", VEC[k][3:0]);
      else                          check("R4 count encode", VEC[k][3:0]);
      drive(RN, HOLD);
    end

    // R7: no flags before power, exact latch latency on direct class-to-power jump
    classify(3);
    check("R7 no flags before power", 4'b0000);
    drive(RP, DEB + 1);
    check("R7 flags one cycle early", 4'b0000);
    @(negedge clk);
    check("R7 latch latency", 4'b0011);
    drive(RN, HOLD);

    // R2: class glitch of DEB-1 cycles inside a mark interval ignored
    classify(1);
    drive(RM, HOLD);
    drive(RC, DEB - 1);
    drive(RM, HOLD);
    drive(RC, HOLD);
    drive(RP, HOLD);
    check("R2 short glitch ignored", 4'b0001);
    drive(RN, HOLD);

    // R3: class, idle, class with no mark counts once
    classify(2);
    drive(RN, HOLD);
    drive(RC, HOLD);
    drive(RP, HOLD);
    check("R3 no mark no event", 4'b0001);
    drive(RN, HOLD);

    // R8: re-arm together with power wins
    classify(4);
    drive(RP, HOLD);
    check("R8 setup four events", 4'b0111);
    @(negedge clk);
    r_rearm = 1'b1;
    repeat (HOLD) @(negedge clk);
    check("R8 rearm over power", 4'b0000);
    drive(RN, HOLD);

    // R9: re-arm mid-count restarts from zero
    classify(3);
    drive(RR, HOLD);
    drive(RN, HOLD);
    drive(RC, HOLD);
    drive(RM, HOLD);
    drive(RC, HOLD);
    drive(RP, HOLD);
    check("R9 fresh count after rearm", 4'b0001);
    drive(RN, HOLD);

    // R10: power loss clears, new activity without re-arm stays low
    classify(3);
    drive(RP, HOLD);
    check("R10 setup", 4'b0011);
    drive(RN, HOLD);
    check("R10 power fall clears", 4'b0000);
    drive(RC, HOLD);
    drive(RM, HOLD);
    drive(RC, HOLD);
    drive(RP, HOLD);
    check("R10 no relatch without rearm", 4'b0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule